// File: doc/BRIEF.md
# Ternary Match Memory with Split One-Hot Output

The block holds 32 stored words of 32 bits. Every word has its own 32-bit ignore mask and a valid flag. A write port places a word and its mask at a chosen slot. A search port presents a key, and all valid slots are compared with it in the same cycle. Any key bit whose mask bit is set in a slot does not take part in that slot's comparison.

Each search result is reported in one of two forms, chosen per search. The compact form gives the binary index of the lowest matching slot. The spread form gives one line per slot on a 16-bit bus over two output cycles: slots 0 to 15 come first and slots 16 to 31 follow. A phase line shows which half is on the bus.

The input side has its own clock, clock enable and asynchronous clear, and so does the output side. The input side registers the search result. The output side registers what appears on the pins.

Top module: `tern_cam`

## Requirements
- R1: Asserting `inClr` invalidates every slot, so no later search matches until a slot is written again. Asserting `outClr` drives `resValid`, `matchOut`, `halfSel` and `addrOut` to 0.
- R2: When `wrEn` and `inClkEn` are high at an `inClk` edge, the word `wrData` and the mask `wrDontCare` are stored in slot `wrAddr`, and that slot becomes valid.
- R3: A search sampled at input edge k (`srchEn` high with `inClkEn` high) compares the key against all slots at once. Its first result cycle appears on the outputs after output edge k+1, with `resValid`=1.
- R4: A bit set to 1 in a slot's mask has no effect on whether that slot matches. A slot whose mask is all ones matches any key.
- R5: A slot that has never been written, or has not been written since `inClr`, never matches. A search with no matching slot reports `resValid`=1, `matchOut`=0 and `addrOut`=0.
- R6: In compact form (`unencMode`=0), the result is one cycle with `matchOut`=1, `halfSel`=0 and `addrOut` equal to the zero-extended index of the lowest matching slot.
- R7: In spread form (`unencMode`=1), the first result cycle has `halfSel`=0 and `addrOut` bit i set exactly when slot i matches, for i from 0 to 15. The next enabled output cycle has `halfSel`=1 and `addrOut` bit i set exactly when slot 16+i matches. `matchOut` shows whether any of the 32 slots matched, in both cycles.
- R8: The output cycle that carries an upper half has priority. A search result that is waiting to be reported in that cycle is discarded.
- R9: When a search and a write happen in the same cycle, the search compares against the contents the slots had before the write. A search in the following cycle sees the new word.
- R10: While `inClkEn` is low, `wrEn` and `srchEn` have no effect. The stored slots and the pending search result keep their values.
- R11: While `outClkEn` is low, all outputs keep their values, and the half that is waiting to be sent stays waiting.
- R12: `outClr` leaves the stored slots untouched. A search issued after `outClr` is released still finds the slots written before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| inClk | input | 1 | Clock of the write, search and input registers |
| inClkEn | input | 1 | Enable for every input-side register |
| inClr | input | 1 | Asynchronous clear of the input side, active high |
| wrEn | input | 1 | Store request |
| wrAddr | input | 5 | Slot index to store into |
| wrData | input | 32 | Word to store |
| wrDontCare | input | 32 | Ignore mask stored with the word (1 = bit ignored) |
| srchEn | input | 1 | Search request |
| srchKey | input | 32 | Key compared against all slots |
| unencMode | input | 1 | Result form for this search: 0 compact index, 1 spread one-hot |
| outClk | input | 1 | Clock of the output registers |
| outClkEn | input | 1 | Enable for every output-side register |
| outClr | input | 1 | Asynchronous clear of the output side, active high |
| resValid | output | 1 | A result cycle is on the outputs |
| matchOut | output | 1 | At least one slot matched the key |
| halfSel | output | 1 | 0: lower slots or compact index; 1: upper slots |
| addrOut | output | 16 | Compact index, or one half of the one-hot match lines |

## Verification
The input-side checks assume that `wrAddr` is always a legal slot index and that the enables and clears change away from the active edge. The bench drives every input shortly after the falling edge, so both conditions hold. The output-side checks assume that `inClk` and `outClk` are the same clock. The bench connects one clock to both, and a reference model advances once per edge. The ordering check for the upper half only applies after an enabled output edge, because a disabled edge repeats the previous state. The random phase toggles both enables with this in mind, and so does the directed case that stalls the outputs in the middle of a two-cycle result.

// File: rtl/tern_cam_pkg.sv
`timescale 1ns/1ps
package tern_cam_pkg;
  // strobes from the output sequencer to the datapath output registers
  typedef struct packed {
    logic sendEnc;   // one-cycle compact index result
    logic sendLo;    // lower half of a spread result
    logic sendHi;    // upper half of a spread result
  } outStrobe_t;
endpackage

// File: rtl/tern_cam_ctl.sv
`timescale 1ns/1ps
module tern_cam_ctl
  import tern_cam_pkg::*;
(
  input  logic       outClk,
  input  logic       outClkEn,
  input  logic       outClr,
  input  logic       srchPend,
  input  logic       modePend,
  output outStrobe_t strb
);
  logic phaseHi;

  always_comb begin
    strb = '0;
    if (phaseHi)       strb.sendHi  = 1'b1;
    else if (srchPend) begin
      if (modePend)    strb.sendLo  = 1'b1;
      else             strb.sendEnc = 1'b1;
    end
  end

  always_ff @(posedge outClk or posedge outClr) begin
    if (outClr)        phaseHi <= 1'b0;
    else if (outClkEn) phaseHi <= strb.sendLo;
  end

  // R8
  phase_one_cycle_chk: assert property (@(posedge outClk) disable iff (outClr)
    (outClkEn && phaseHi) |=> !phaseHi);
endmodule

// File: rtl/tern_cam_dp.sv
`timescale 1ns/1ps
module tern_cam_dp
  import tern_cam_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32,
  parameter int OUT_W = DEPTH / 2
) (
  input  logic                     inClk,
  input  logic                     inClkEn,
  input  logic                     inClr,
  input  logic                     wrEn,
  input  logic [$clog2(DEPTH)-1:0] wrAddr,
  input  logic [WIDTH-1:0]         wrData,
  input  logic [WIDTH-1:0]         wrDontCare,
  input  logic                     srchEn,
  input  logic [WIDTH-1:0]         srchKey,
  input  logic                     unencMode,
  input  logic                     outClk,
  input  logic                     outClkEn,
  input  logic                     outClr,
  input  outStrobe_t               strb,
  output logic                     srchPend,
  output logic                     modePend,
  output logic                     resValid,
  output logic                     matchOut,
  output logic                     halfSel,
  output logic [OUT_W-1:0]         addrOut
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] cellData [DEPTH];
  logic [WIDTH-1:0] cellMask [DEPTH];
  logic [DEPTH-1:0] cellValid;
  logic [DEPTH-1:0] hitNow;
  logic [DEPTH-1:0] hitQ;

  // storage slots and their parallel comparators
  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge inClk or posedge inClr) begin
      if (inClr) begin
        cellData[g]  <= '0;
        cellMask[g]  <= '0;
        cellValid[g] <= 1'b0;
      end else if (inClkEn && wrEn && wrAddr == AW'(g)) begin
        cellData[g]  <= wrData;
        cellMask[g]  <= wrDontCare;
        cellValid[g] <= 1'b1;
      end
    end
    assign hitNow[g] = cellValid[g] &&
                       (((srchKey ^ cellData[g]) & ~cellMask[g]) == '0);
  end

  // input result register: sees slot contents from before a same-edge write
  always_ff @(posedge inClk or posedge inClr) begin
    if (inClr) begin
      hitQ     <= '0;
      srchPend <= 1'b0;
      modePend <= 1'b0;
    end else if (inClkEn) begin
      hitQ     <= hitNow;
      srchPend <= srchEn;
      modePend <= unencMode;
    end
  end

  // lowest matching index
  logic [AW-1:0] firstIdx;
  always_comb begin
    firstIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (hitQ[i]) firstIdx = AW'(i);
  end

  logic             anyHit;
  logic [OUT_W-1:0] hiHold;
  logic             anyHold;
  assign anyHit = |hitQ;

  always_ff @(posedge outClk or posedge outClr) begin
    if (outClr) begin
      resValid <= 1'b0;
      matchOut <= 1'b0;
      halfSel  <= 1'b0;
      addrOut  <= '0;
      hiHold   <= '0;
      anyHold  <= 1'b0;
    end else if (outClkEn) begin
      if (strb.sendHi) begin
        resValid <= 1'b1;
        matchOut <= anyHold;
        halfSel  <= 1'b1;
        addrOut  <= hiHold;
      end else if (strb.sendLo) begin
        resValid <= 1'b1;
        matchOut <= anyHit;
        halfSel  <= 1'b0;
        addrOut  <= hitQ[OUT_W-1:0];
        hiHold   <= hitQ[DEPTH-1:OUT_W];
        anyHold  <= anyHit;
      end else if (strb.sendEnc) begin
        resValid <= 1'b1;
        matchOut <= anyHit;
        halfSel  <= 1'b0;
        addrOut  <= OUT_W'(firstIdx);
      end else begin
        resValid <= 1'b0;
        matchOut <= 1'b0;
        halfSel  <= 1'b0;
        addrOut  <= '0;
      end
    end
  end

  // R2
  wr_sets_valid_chk: assert property (@(posedge inClk) disable iff (inClr)
    (inClkEn && wrEn) |=> cellValid[$past(wrAddr)]);

  // R5
  empty_no_hit_chk: assert property (@(posedge inClk) disable iff (inClr)
    (inClkEn && srchEn) |=> ((hitQ & ~$past(cellValid)) == '0));

  // R10
  stall_hold_chk: assert property (@(posedge inClk) disable iff (inClr)
    !inClkEn |=> ($stable(cellValid) && $stable(hitQ) && $stable(srchPend)));

  // R7
  split_order_chk: assert property (@(posedge outClk) disable iff (outClr)
    (halfSel && $past(outClkEn)) |-> $past(resValid && !halfSel));

  // R1
  idle_quiet_chk: assert property (@(posedge outClk) disable iff (outClr)
    !resValid |-> (addrOut == '0 && !matchOut && !halfSel));

  // R11
  out_hold_chk: assert property (@(posedge outClk) disable iff (outClr)
    !outClkEn |=> ($stable(addrOut) && $stable(resValid) && $stable(halfSel)
                   && $stable(matchOut)));
endmodule

// File: rtl/tern_cam.sv
`timescale 1ns/1ps
module tern_cam #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32,
  parameter int OUT_W = DEPTH / 2
) (
  input  logic                     inClk,
  input  logic                     inClkEn,
  input  logic                     inClr,
  input  logic                     wrEn,
  input  logic [$clog2(DEPTH)-1:0] wrAddr,
  input  logic [WIDTH-1:0]         wrData,
  input  logic [WIDTH-1:0]         wrDontCare,
  input  logic                     srchEn,
  input  logic [WIDTH-1:0]         srchKey,
  input  logic                     unencMode,
  input  logic                     outClk,
  input  logic                     outClkEn,
  input  logic                     outClr,
  output logic                     resValid,
  output logic                     matchOut,
  output logic                     halfSel,
  output logic [OUT_W-1:0]         addrOut
);
  tern_cam_pkg::outStrobe_t strb;
  logic srchPend;
  logic modePend;

  tern_cam_ctl u_ctl (
    .outClk(outClk), .outClkEn(outClkEn), .outClr(outClr),
    .srchPend(srchPend), .modePend(modePend), .strb(strb)
  );

  tern_cam_dp #(.DEPTH(DEPTH), .WIDTH(WIDTH), .OUT_W(OUT_W)) u_dp (
    .inClk(inClk), .inClkEn(inClkEn), .inClr(inClr),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .wrDontCare(wrDontCare),
    .srchEn(srchEn), .srchKey(srchKey), .unencMode(unencMode),
    .outClk(outClk), .outClkEn(outClkEn), .outClr(outClr),
    .strb(strb), .srchPend(srchPend), .modePend(modePend),
    .resValid(resValid), .matchOut(matchOut), .halfSel(halfSel),
    .addrOut(addrOut)
  );
endmodule

// File: tb/tern_cam_bench.sv
`timescale 1ns/1ps
module tern_cam_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        inClkEn, inClr, wrEn, srchEn, unencMode, outClkEn, outClr;
  logic [4:0]  wrAddr;
  logic [31:0] wrData, wrDontCare, srchKey;
  logic        resValid, matchOut, halfSel;
  logic [15:0] addrOut;

  tern_cam u_tern_cam (
    .inClk(clk), .inClkEn(inClkEn), .inClr(inClr),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .wrDontCare(wrDontCare),
    .srchEn(srchEn), .srchKey(srchKey), .unencMode(unencMode),
    .outClk(clk), .outClkEn(outClkEn), .outClr(outClr),
    .resValid(resValid), .matchOut(matchOut), .halfSel(halfSel),
    .addrOut(addrOut)
  );

  int    errors = 0;
  int    checks = 0;
  string curReq = "R1";
  bit    done = 0;

  // behavioural reference model
  bit [31:0] mData [32];
  bit [31:0] mMask [32];
  bit [31:0] mValid, mHit;
  bit        mSrchV, mMode, mPhase, mAnyHold;
  bit [15:0] mHiHold;
  bit        eV, eM, eH;
  bit [15:0] eA;

  function automatic int lowest(bit [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic resetIn();
    mValid = '0; mHit = '0; mSrchV = 0; mMode = 0;
    for (int i = 0; i < 32; i++) begin mData[i] = '0; mMask[i] = '0; end
  endtask

  task automatic resetOut();
    mPhase = 0; mAnyHold = 0; mHiHold = '0;
    eV = 0; eM = 0; eH = 0; eA = '0;
  endtask

  always @(posedge clk) begin
    if (outClr) resetOut();
    else if (outClkEn) begin
      if (mPhase) begin
        eV = 1; eM = mAnyHold; eA = mHiHold; eH = 1; mPhase = 0;
      end else if (mSrchV && mMode) begin
        eV = 1; eM = |mHit; eA = mHit[15:0]; eH = 0;
        mHiHold = mHit[31:16]; mAnyHold = |mHit; mPhase = 1;
      end else if (mSrchV) begin
        eV = 1; eM = |mHit; eA = 16'(lowest(mHit)); eH = 0;
      end else begin
        eV = 0; eM = 0; eA = '0; eH = 0;
      end
    end
    if (inClr) resetIn();
    else if (inClkEn) begin
      bit [31:0] h;
      h = '0;
      for (int i = 0; i < 32; i++)
        if (mValid[i] && (((srchKey ^ mData[i]) & ~mMask[i]) == 0)) h[i] = 1;
      mHit = h; mSrchV = srchEn; mMode = unencMode;
      if (wrEn) begin
        mData[wrAddr] = wrData; mMask[wrAddr] = wrDontCare; mValid[wrAddr] = 1;
      end
    end
  end

  // cycle compare against the model
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (resValid !== eV || matchOut !== eM || halfSel !== eH || addrOut !== eA) begin
        errors++;
        $display("FAIL %s: got v=%0b m=%0b h=%0b a=%h expected v=%0b m=%0b h=%0b a=%h",
                 curReq, resValid, matchOut, halfSel, addrOut, eV, eM, eH, eA);
      end
    end
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic idle(int n);
    repeat (n) begin tick(); wrEn = 0; srchEn = 0; end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d, logic [31:0] m);
    tick(); wrEn = 1; srchEn = 0; wrAddr = a; wrData = d; wrDontCare = m;
  endtask

  task automatic srch(logic [31:0] k, logic md);
    tick(); wrEn = 0; srchEn = 1; srchKey = k; unencMode = md;
  endtask

  // result of a search is visible after two ticks
  task automatic look(string req, logic v, logic m, logic h, logic [15:0] a);
    chk(req, {28'd0, v, m, h, 1'b0}, {28'd0, resValid, matchOut, halfSel, 1'b0});
    chk(req, {16'd0, a}, {16'd0, addrOut});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    inClr = 1; outClr = 1; inClkEn = 1; outClkEn = 1;
    wrEn = 0; srchEn = 0; unencMode = 0;
    wrAddr = '0; wrData = '0; wrDontCare = '0; srchKey = '0;
    resetIn(); resetOut();
    idle(3);
    // R1: outputs cleared during reset
    look("R1", 0, 0, 0, 16'h0);
    tick(); inClr = 0; outClr = 0;

    // R5: empty array never matches
    curReq = "R5";
    srch(32'h0, 0); idle(2);
    look("R5", 1, 0, 0, 16'h0);

    curReq = "R2";
    wr(5'd3, 32'hA5A5_0000, 32'h0000_FFFF);
    wr(5'd12, 32'h1234_5678, 32'h0);
    wr(5'd20, 32'h1234_5678, 32'h0);
    idle(1);

    // R6: lowest of slots 12 and 20
    curReq = "R6";
    srch(32'h1234_5678, 0); idle(2);
    look("R6", 1, 1, 0, 16'd12);

    // R4: masked low half of slot 3
    curReq = "R4";
    srch(32'hA5A5_BEEF, 0); idle(2);
    look("R4", 1, 1, 0, 16'd3);

    // R7: spread form, slots 12 and 20
    curReq = "R7";
    srch(32'h1234_5678, 1); idle(2);
    look("R7", 1, 1, 0, 16'h1000);
    idle(1);
    look("R7", 1, 1, 1, 16'h0010);
    idle(2);

    // R9: write and search in one cycle sees old contents
    curReq = "R9";
    tick(); wrEn = 1; srchEn = 1; wrAddr = 5'd7; wrData = 32'hCAFE_F00D;
    wrDontCare = 32'h0; srchKey = 32'hCAFE_F00D; unencMode = 0;
    idle(2);
    look("R9", 1, 0, 0, 16'h0);
    srch(32'hCAFE_F00D, 0); idle(2);
    look("R9", 1, 1, 0, 16'd7);

    // R10: stalled input side ignores write and search
    curReq = "R10";
    idle(1);
    tick(); inClkEn = 0; wrEn = 1; srchEn = 1; wrAddr = 5'd9;
    wrData = 32'h0BAD_BEEF; wrDontCare = 32'h0; srchKey = 32'h1234_5678;
    idle(2);
    look("R10", 0, 0, 0, 16'h0);
    inClkEn = 1;
    srch(32'h0BAD_BEEF, 0); idle(2);
    look("R10", 1, 0, 0, 16'h0);

    // R4: all-ignore slot matches anything
    curReq = "R4";
    wr(5'd31, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    srch(32'h0BAD_BEEF, 0); idle(2);
    look("R4", 1, 1, 0, 16'd31);

    // R8: search right after a spread search is dropped
    curReq = "R8";
    srch(32'h1234_5678, 1);
    srch(32'hCAFE_F00D, 0);
    idle(1);
    look("R8", 1, 1, 0, 16'h1000);
    idle(1);
    look("R8", 1, 1, 1, 16'h8010);
    idle(1);
    look("R8", 0, 0, 0, 16'h0);

    // R11: stalled output side holds the lower half
    curReq = "R11";
    srch(32'hA5A5_0001, 1); idle(1);
    tick(); outClkEn = 0;
    idle(3);
    look("R11", 1, 1, 0, 16'h0008);
    outClkEn = 1;
    idle(1);
    look("R11", 1, 1, 1, 16'h8000);
    idle(2);

    // R12: output clear keeps stored slots
    curReq = "R12";
    srch(32'h1234_5678, 0); idle(2);
    outClr = 1; resetOut(); #1;
    chk("R12", {31'd0, resValid}, 32'd0);
    idle(1); outClr = 0;
    srch(32'h1234_5678, 0); idle(2);
    look("R12", 1, 1, 0, 16'd12);

    // R1: input clear invalidates every slot
    curReq = "R1";
    tick(); inClr = 1; resetIn();
    idle(1); inClr = 0;
    srch(32'h1234_5678, 0); idle(2);
    look("R1", 1, 0, 0, 16'h0);

    // R3: random traffic against the model
    curReq = "R3";
    for (int n = 0; n < 600; n++) begin
      logic [31:0] ks [4];
      ks[0] = 32'h1234_5678; ks[1] = 32'hA5A5_BEEF;
      ks[2] = 32'hCAFE_F00D; ks[3] = 32'h0000_0001;
      tick();
      inClkEn   = ($urandom_range(0, 7) != 0);
      outClkEn  = ($urandom_range(0, 7) != 0);
      wrEn      = ($urandom_range(0, 2) == 0);
      srchEn    = ($urandom_range(0, 1) == 0);
      wrAddr    = 5'($urandom_range(0, 31));
      wrData    = ks[$urandom_range(0, 3)];
      wrDontCare = ($urandom_range(0, 3) == 0) ? ($urandom & $urandom) : 32'h0;
      srchKey   = ks[$urandom_range(0, 3)] ^ (($urandom_range(0, 5) == 0) ? 32'h10 : 32'h0);
      unencMode = 1'($urandom_range(0, 1));
    end
    inClkEn = 1; outClkEn = 1;
    idle(4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule